// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of an external NOR flash. Once software or another engine has issued a program or erase command, the poller works out when that embedded operation has finished. While the operation runs, every read of the flash returns a status word instead of array data. The poller issues reads over a simple request/acknowledge handshake. It compares the toggle bit (bit 6) across successive status words and looks at the error bit (bit 5).

A steady toggle bit means the operation has completed and passed. A toggle bit that keeps changing while the error bit is low means the operation is still running, so polling continues. When the error bit is seen during toggling, the completion may have raced with the flag. The poller therefore takes two confirmation reads before it decides: if the toggle bit is stable across that pair the result is pass, and otherwise it is fail. A limit on the poll count, loaded at start, stops a flash that never settles and forces a failing result.

The result is a single-cycle done pulse with a pass flag. The pass flag holds its value until the next accepted start.

Top module: `flash_toggle_poller`

## Requirements
- R1: `rd_req_o` rises on an accepted start and stays high until a cycle in which `rd_ack_i` is high. Each such cycle consumes exactly one word. `rd_req_o` is low whenever the poller is idle, including the cycle in which `done_o` is high.
- R2: The first word read after start sets the reference toggle bit (bit 6). If the next word has the same bit 6, the operation finishes with pass.
- R3: If bit 6 differs from the previous word and bit 5 is 0, polling continues. Each new word is compared with the word read just before it.
- R4: If bit 6 differs and bit 5 is 1, exactly two more words are read. Equal bit 6 in those two words gives pass.
- R5: Differing bit 6 in those two confirmation words gives fail.
- R6: With N taken from `max_polls_i` at start (0 acts as 1), the Nth comparison that sees a toggle with bit 5 at 0 finishes the operation with fail. No further reads follow.
- R7: `done_o` is high for exactly one cycle. That cycle immediately follows the clock edge that accepts the deciding word.
- R8: `pass_o` changes only at the end of an operation. An accepted start clears it.
- R9: A start pulse while an operation is in progress has no effect.
- R10: Status bits other than 5 and 6 have no effect on the sequence or the result.
- R11: After reset, `rd_req_o`, `done_o` and `pass_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling; accepted only when idle |
| max_polls_i | input | CNT_W | Poll limit, sampled at start |
| rd_req_o | output | 1 | Read request to the flash interface |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | DATA_W | Status word returned by the read |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result flag, high means pass |

## Verification
The hardest case to reach is the race at the end of an operation. Here the error bit shows up alongside a toggle, and the outcome then depends only on whether the two confirmation reads agree. A random read responder cannot land on this reliably. The stimulus therefore builds status-word sequences with a chosen number of toggles, followed by a stable word, an error word with an agreeing pair, or an error word with a disagreeing pair. It mixes these with fully random words and random poll limits, so the timeout also strikes in the middle of a toggle run.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BASE = 3'd1,
    ST_CMP  = 3'd2,
    ST_CFA  = 3'd3,
    ST_CFB  = 3'd4
  } ftp_state_t;

  // A bit toggled between two status reads
  function automatic logic bit_moved(input logic now_bit, input logic prev_bit);
    return now_bit ^ prev_bit;
  endfunction

  // Limit reached when one more toggling poll meets or passes the limit
  function automatic logic limit_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction
endpackage

// File: rtl/ftp_read_port.sv
module ftp_read_port #(
  parameter int DATA_W  = 16,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic              active_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic              beat_o,
  output logic              tog_o,
  output logic              err_o
);
  logic unused_rest;

  assign req_o  = active_i;
  assign beat_o = active_i & ack_i;
  assign tog_o  = data_i[TOG_BIT];
  assign err_o  = data_i[ERR_BIT];
  assign unused_rest = ^data_i;
endmodule

// File: rtl/ftp_bit_tracker.sv
module ftp_bit_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic bit_i,
  output logic moved_o
);
  import ftp_pkg::*;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= 1'b0;
    else if (load_i) prev_q <= bit_i;
  end

  assign moved_o = bit_moved(bit_i, prev_q);
endmodule

// File: rtl/ftp_poll_counter.sv
module ftp_poll_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             bump_i,
  output logic             expire_o
);
  import ftp_pkg::*;
  localparam int PAD = 32 - CNT_W;
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             hit;

  assign hit      = limit_hit({{PAD{1'b0}}, cnt_q}, {{PAD{1'b0}}, lim_q});
  assign expire_o = bump_i & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (bump_i && !hit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: the count of toggling polls never reaches the limit
  p_count_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) || (cnt_q < lim_q));
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller #(
  parameter int DATA_W  = 16,
  parameter int TOG_BIT = 6,
  parameter int ERR_BIT = 5,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic              pass_o
);
  import ftp_pkg::*;

  ftp_state_t state_q, state_d;
  logic beat, tog_bit, err_bit, moved, expire;
  logic start_accept, finish_evt, finish_pass, track_load, poll_bump;

  ftp_read_port #(.DATA_W(DATA_W), .TOG_BIT(TOG_BIT), .ERR_BIT(ERR_BIT)) u_port (
    .active_i (state_q != ST_IDLE),
    .ack_i    (rd_ack_i),
    .data_i   (rd_data_i),
    .req_o    (rd_req_o),
    .beat_o   (beat),
    .tog_o    (tog_bit),
    .err_o    (err_bit)
  );

  assign track_load = beat && (state_q != ST_CFB);

  ftp_bit_tracker u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (track_load),
    .bit_i   (tog_bit),
    .moved_o (moved)
  );

  assign start_accept = start_i && (state_q == ST_IDLE);
  assign poll_bump    = beat && (state_q == ST_CMP) && moved && !err_bit;

  ftp_poll_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_accept),
    .limit_i  (max_polls_i),
    .bump_i   (poll_bump),
    .expire_o (expire)
  );

  always_comb begin
    state_d     = state_q;
    finish_evt  = 1'b0;
    finish_pass = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_accept) state_d = ST_BASE;
      ST_BASE: if (beat) state_d = ST_CMP;
      ST_CMP: if (beat) begin
        if (!moved) begin
          finish_evt  = 1'b1;
          finish_pass = 1'b1;
        end else if (!err_bit) begin
          finish_evt = expire;
        end else begin
          state_d = ST_CFA;
        end
      end
      ST_CFA: if (beat) state_d = ST_CFB;
      ST_CFB: if (beat) begin
        finish_evt  = 1'b1;
        finish_pass = !moved;
      end
      default: state_d = ST_IDLE;
    endcase
    if (finish_evt) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      pass_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= finish_evt;
      if (finish_evt)        pass_o <= finish_pass;
      else if (start_accept) pass_o <= 1'b0;
    end
  end

  // R1: a request is held until it is acknowledged
  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o);
  // R1: no request while the completion pulse is out
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o);
  // R7: completion pulse lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: completion follows an acknowledged read
  p_done_after_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |-> beat);
  // R8: result flag holds between events
  p_pass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !finish_evt && !start_accept |=> $stable(pass_o));
  // R9: start while busy leaves the state alone
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && rd_req_o && !rd_ack_i |=> rd_req_o && $stable(state_q));
endmodule

// File: tb/test_flash_toggle_poller.sv
module test_flash_toggle_poller;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, rd_ack_i = 1'b0;
  logic [CW-1:0] max_polls_i = '0;
  logic [DW-1:0] rd_data_i = '0;
  logic rd_req_o, done_o, pass_o;

  int n_chk = 0, n_bad = 0, cycles = 0, idx = 0;
  logic [DW-1:0] words [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_toggle_poller #(.DATA_W(DW), .CNT_W(CW)) i_flash_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_polls_i(max_polls_i),
    .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .pass_o(pass_o));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // read responder: random latency, one acknowledge per word
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req_o && rst_n) begin
        repeat ($urandom % 3) @(negedge clk);
        rd_ack_i  = 1'b1;
        rd_data_i = words[idx % 64];
        idx++;
        @(negedge clk);
        rd_ack_i  = 1'b0;
        rd_data_i = DW'($urandom);
      end
    end
  end

  // independent statement of the decision procedure
  function automatic void model(input int mx, output bit ps, output int nr);
    bit prev = words[0][6];
    int cnt = 0;
    int i = 1;
    ps = 1'b0; nr = 0;
    while (i < 60) begin
      if (words[i][6] == prev) begin ps = 1'b1; nr = i + 1; return; end
      if (!words[i][5]) begin
        if (cnt + 1 >= mx) begin ps = 1'b0; nr = i + 1; return; end
        cnt++; prev = words[i][6]; i++;
      end else begin
        ps = (words[i+1][6] == words[i+2][6]); nr = i + 3; return;
      end
    end
  endfunction

  // kind: 0 stable end, 1 error + agreeing pair, 2 error + disagreeing pair, 3 random
  task automatic build(input int ntog, input int kind, input bit scramble);
    bit b = 1'($urandom);
    for (int i = 0; i < 64; i++) begin
      words[i] = DW'($urandom);
      if (kind == 3) words[i][5] = ($urandom % 5 == 0);
    end
    if (kind != 3) begin
      words[0][6] = b;
      for (int i = 1; i <= ntog; i++) begin b = ~b; words[i][6] = b; words[i][5] = 1'b0; end
      if (kind == 0) words[ntog+1][6] = b;
      else begin
        words[ntog+1][6] = ~b; words[ntog+1][5] = 1'b1;
        words[ntog+3][6] = (kind == 1) ? words[ntog+2][6] : ~words[ntog+2][6];
      end
    end
    if (!scramble) for (int i = 0; i < 64; i++) words[i] = words[i] & 16'h0060;
  endtask

  task automatic run(input int mx, input bit mid_start, input string tag);
    bit ps; int nr; int wait_c = 0; int dones = 0;
    model(mx, ps, nr);
    idx = 0;
    max_polls_i = CW'(mx);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(pass_o == 1'b0, {tag, " R8 cleared by start"}, pass_o, 0);
    check(rd_req_o == 1'b1, {tag, " R1 request after start"}, rd_req_o, 1);
    if (mid_start) begin
      repeat (2) @(negedge clk);
      start_i = 1'b1; max_polls_i = '0;
      @(negedge clk); start_i = 1'b0;
    end
    while (!done_o && wait_c < 2000) begin @(negedge clk); wait_c++; end
    if (done_o) dones++;
    check(pass_o == ps, {tag, " R2-R6 result"}, pass_o, ps);
    check(idx == nr, {tag, " R3 words consumed"}, idx, nr);
    check(rd_req_o == 1'b0, {tag, " R1 idle at done"}, rd_req_o, 0);
    @(negedge clk);
    check(done_o == 1'b0, {tag, " R7 pulse width"}, done_o, 0);
    repeat (3) @(negedge clk);
    check(pass_o == ps, {tag, " R8 result held"}, pass_o, ps);
    check(dones == 1 && idx == nr, {tag, " R9 single completion"}, idx, nr);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) words[i] = '0;
    repeat (3) @(negedge clk);
    check(rd_req_o == 1'b0 && done_o == 1'b0 && pass_o == 1'b0, "R11 reset outputs", {rd_req_o, done_o, pass_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_req_o == 1'b0, "R11 idle after reset", rd_req_o, 0);

    build(0, 0, 1'b0); run(8, 1'b0, "R2 immediate stable");
    build(5, 0, 1'b0); run(20, 1'b0, "R3 toggle then settle");
    build(3, 1, 1'b0); run(20, 1'b0, "R4 error with agreeing pair");
    build(4, 2, 1'b0); run(20, 1'b0, "R5 error with disagreeing pair");
    build(10, 0, 1'b0); run(4, 1'b0, "R6 limit four");
    build(10, 0, 1'b0); run(0, 1'b0, "R6 limit zero");
    build(6, 0, 1'b1); run(20, 1'b0, "R10 noisy other bits");
    build(6, 1, 1'b0); run(20, 1'b1, "R9 start while busy");

    for (int t = 0; t < 200; t++) begin
      build($urandom % 12, $urandom % 4, 1'b1);
      run(($urandom % 15), ($urandom % 4 == 0), "R4 R5 R6 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule